// File: doc/BRIEF.md
# CAN Message Queue and Mailbox Dispatcher

This block sits between a host-side command bridge and a CAN controller and holds CAN messages as fixed 128-bit records. Each of two channels has a transmit queue and a receive queue. The host pushes transmit records and pops receive records one at a time. The block sends channel-0 transmit records into the controller's transmit mailboxes, loading the lowest-numbered free mailbox first. It moves messages waiting in the controller's two hardware receive FIFOs into the channel-0 receive queue.

The block publishes a packed occupancy word for each channel and a four-bit status map. The status map drives an interrupt line. Writing a new value with the enable bit set to the controller's control word empties all four queues. The host can then start again from a known state.

Top module: `canq_dispatch`

## Requirements
- R1: A record is 128 bits: identifier word in [127:96], timestamp in [95:80], data length in [79:64], data bytes in [63:0]. A record handed to a mailbox is the queued record with bit 96 (identifier bit 0, the transmit request) forced to 1. All other bits are unchanged.
- R2: A host push (`host_tx_push`, `host_tx_chan` 0 or 1) appends `host_tx_rec` to that channel's transmit queue. Each queue holds DEPTH records (32 by default). A push to a full queue, with no pop in the same cycle, is dropped.
- R3: A host pop (`host_rx_pop`, `host_rx_chan`) removes the head of that channel's receive queue. The head appears on `host_rx_rec` with `host_rx_valid` high one cycle later. A pop from an empty queue returns all zeros and changes no count.
- R4: While the channel-0 transmit queue is non-empty, the block loads one mailbox per cycle. It picks the lowest-index mailbox whose `mb_empty` bit is 1. `mb_load_valid`, `mb_load_idx` and `mb_load_rec` carry the load, and the head record leaves the queue at that edge. The channel-1 transmit queue is never dispatched.
- R5: Receive FIFO 0 is drained before FIFO 1. The block takes one entry per cycle into the channel-0 receive queue, but only while that queue has room. It pulses the matching `rxf_release` bit (bit 0 for FIFO 0, bit 1 for FIFO 1) for each entry taken. A FIFO is pending when its two-bit count is nonzero.
- R6: `occ_ch0` and `occ_ch1` carry the transmit record count in [31:16] and the receive record count in [15:0].
- R7: `status` bit 0 is set when the channel-0 transmit queue is full. Bit 1 is set when the channel-0 receive queue is non-empty. Bit 2 is set when the channel-1 transmit queue is full. Bit 3 is set when the channel-1 receive queue is non-empty.
- R8: `irq` is 1 exactly when `status` is nonzero.
- R9: When `ctrl_word` differs from its value in the previous cycle and its new bit 0 is 1, all four queues become empty at the next edge. Any other change, or no change, leaves them untouched. The previous value is 0 after reset.
- R10: A push and a pop on the same queue in one cycle both take effect and the count stays the same. This holds even when the queue is full.
- R11: In a flush cycle no mailbox is loaded, no receive entry is released, and a host push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Controller control word; bit 0 is enable |
| host_tx_push | input | 1 | Push a transmit record |
| host_tx_chan | input | 1 | Channel of the push |
| host_tx_rec | input | 128 | Record to push |
| host_rx_pop | input | 1 | Pop a receive record |
| host_rx_chan | input | 1 | Channel of the pop |
| host_rx_valid | output | 1 | Pop response valid |
| host_rx_rec | output | 128 | Popped record, zero if queue was empty |
| mb_empty | input | MB_N | Mailbox empty flags |
| mb_load_valid | output | 1 | A mailbox is loaded this cycle |
| mb_load_idx | output | IW | Index of loaded mailbox |
| mb_load_rec | output | 128 | Record with request bit set |
| rxf_count0 | input | 2 | Pending entries in receive FIFO 0 |
| rxf_msg0 | input | 128 | Head entry of receive FIFO 0 |
| rxf_count1 | input | 2 | Pending entries in receive FIFO 1 |
| rxf_msg1 | input | 128 | Head entry of receive FIFO 1 |
| rxf_release | output | 2 | Release pulse per receive FIFO |
| occ_ch0 | output | 32 | Channel-0 occupancy word |
| occ_ch1 | output | 32 | Channel-1 occupancy word |
| status | output | 4 | Status bitmap |
| irq | output | 1 | Interrupt request |

## Verification
Three same-cycle collisions are provoked on purpose.

- A host push meets a mailbox dispatch on a full channel-0 transmit queue. The bench judges it by the count staying at 32 and by the expected head record reaching mailbox 0.
- A host pop meets a FIFO drain on the channel-0 receive queue. The old head must come back while the new entry stays queued.
- A flush meets a push, a free mailbox and a pending FIFO entry. The load and release outputs are sampled before the edge, and every count is checked to be zero after it.

// File: rtl/canq_pkg.sv
package canq_pkg;

    localparam int REC_W  = 128;
    localparam int NUM_Q  = 4;
    localparam int QI_TX0 = 0;
    localparam int QI_RX0 = 1;
    localparam int QI_TX1 = 2;
    localparam int QI_RX1 = 3;

    typedef struct packed {
        logic [31:0] ident;
        logic [15:0] stamp;
        logic [15:0] dlen;
        logic [63:0] payload;
    } can_rec_t;

    // mark a record for transmission: identifier bit 0 is the request flag
    function automatic can_rec_t set_req(can_rec_t r);
        can_rec_t o;
        o          = r;
        o.ident[0] = 1'b1;
        return o;
    endfunction

    function automatic logic [31:0] pack_occ(logic [15:0] tx_n, logic [15:0] rx_n);
        return {tx_n, rx_n};
    endfunction

endpackage

// File: rtl/canq_fifo.sv
module canq_fifo
    import canq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  can_rec_t      push_rec,
    input  logic          pop,
    output can_rec_t      head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    can_rec_t      store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          pop_ok;
    logic          push_ok;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && push_ok) store[wr_ptr] <= push_rec;
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(count));

    assert_pushpop_R10: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty && !flush) |=> $stable(count));

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/canq_mb_pick.sv
module canq_mb_pick #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          want,
    input  logic [N-1:0]  mb_free,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          valid
);

    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_scan
        assign grant[i]  = want && mb_free[i] && !seen[i];
        assign seen[i+1] = seen[i] || mb_free[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    assign valid = |grant;

endmodule

// File: rtl/canq_status.sv
module canq_status
    import canq_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic [CW-1:0] tx0_cnt,
    input  logic [CW-1:0] rx0_cnt,
    input  logic [CW-1:0] tx1_cnt,
    input  logic [CW-1:0] rx1_cnt,
    input  logic          tx0_full,
    input  logic          rx0_empty,
    input  logic          tx1_full,
    input  logic          rx1_empty,
    output logic [31:0]   occ_ch0,
    output logic [31:0]   occ_ch1,
    output logic [3:0]    status,
    output logic          irq
);

    assign occ_ch0 = pack_occ(16'(tx0_cnt), 16'(rx0_cnt));
    assign occ_ch1 = pack_occ(16'(tx1_cnt), 16'(rx1_cnt));
    assign status  = {!rx1_empty, tx1_full, !rx0_empty, tx0_full};
    assign irq     = |status;

endmodule

// File: rtl/canq_dispatch.sv
module canq_dispatch
    import canq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int MB_N  = 3,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (MB_N > 1) ? $clog2(MB_N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       ctrl_word,
    input  logic              host_tx_push,
    input  logic              host_tx_chan,
    input  logic [REC_W-1:0]  host_tx_rec,
    input  logic              host_rx_pop,
    input  logic              host_rx_chan,
    output logic              host_rx_valid,
    output logic [REC_W-1:0]  host_rx_rec,
    input  logic [MB_N-1:0]   mb_empty,
    output logic              mb_load_valid,
    output logic [IW-1:0]     mb_load_idx,
    output logic [REC_W-1:0]  mb_load_rec,
    input  logic [1:0]        rxf_count0,
    input  logic [REC_W-1:0]  rxf_msg0,
    input  logic [1:0]        rxf_count1,
    input  logic [REC_W-1:0]  rxf_msg1,
    output logic [1:0]        rxf_release,
    output logic [31:0]       occ_ch0,
    output logic [31:0]       occ_ch1,
    output logic [3:0]        status,
    output logic              irq
);

    logic [31:0]   ctrl_prev;
    logic          flush;
    logic          q_push  [NUM_Q];
    logic          q_pop   [NUM_Q];
    can_rec_t      q_in    [NUM_Q];
    can_rec_t      q_head  [NUM_Q];
    logic [CW-1:0] q_cnt   [NUM_Q];
    logic          q_full  [NUM_Q];
    logic          q_empty [NUM_Q];
    logic          rx_room;
    logic          drain0;
    logic          drain1;
    logic [MB_N-1:0] grant;
    int            rx_sel;

    // enable-edge detection on the control word
    always_ff @(posedge clk) begin
        if (rst) ctrl_prev <= '0;
        else     ctrl_prev <= ctrl_word;
    end
    assign flush = ctrl_word[0] && (ctrl_word != ctrl_prev);

    // receive drain: FIFO 0 first, only while the queue can take it
    assign rx_room = !q_full[QI_RX0] || q_pop[QI_RX0];
    assign drain0  = !flush && rx_room && (rxf_count0 != 2'd0);
    assign drain1  = !flush && rx_room && (rxf_count0 == 2'd0) && (rxf_count1 != 2'd0);
    assign rxf_release = {drain1, drain0};

    canq_mb_pick #(.N(MB_N)) u_pick (
        .want    (!flush && !q_empty[QI_TX0]),
        .mb_free (mb_empty),
        .grant   (grant),
        .idx     (mb_load_idx),
        .valid   (mb_load_valid)
    );
    assign mb_load_rec = set_req(q_head[QI_TX0]);

    always_comb begin
        q_push[QI_TX0] = !flush && host_tx_push && !host_tx_chan;
        q_push[QI_TX1] = !flush && host_tx_push &&  host_tx_chan;
        q_push[QI_RX0] = drain0 || drain1;
        q_push[QI_RX1] = 1'b0;
        q_in[QI_TX0]   = can_rec_t'(host_tx_rec);
        q_in[QI_TX1]   = can_rec_t'(host_tx_rec);
        q_in[QI_RX0]   = can_rec_t'(drain0 ? rxf_msg0 : rxf_msg1);
        q_in[QI_RX1]   = '0;
        q_pop[QI_TX0]  = mb_load_valid;
        q_pop[QI_TX1]  = 1'b0;
        q_pop[QI_RX0]  = !flush && host_rx_pop && !host_rx_chan;
        q_pop[QI_RX1]  = !flush && host_rx_pop &&  host_rx_chan;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        canq_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .push     (q_push[q]),
            .push_rec (q_in[q]),
            .pop      (q_pop[q]),
            .head     (q_head[q]),
            .count    (q_cnt[q]),
            .full     (q_full[q]),
            .empty    (q_empty[q])
        );
    end

    // pop response, registered
    assign rx_sel = host_rx_chan ? QI_RX1 : QI_RX0;
    always_ff @(posedge clk) begin
        if (rst) begin
            host_rx_valid <= 1'b0;
            host_rx_rec   <= '0;
        end else begin
            host_rx_valid <= host_rx_pop;
            host_rx_rec   <= (host_rx_pop && !flush && !q_empty[rx_sel])
                             ? REC_W'(q_head[rx_sel]) : '0;
        end
    end

    canq_status #(.CW(CW)) u_status (
        .tx0_cnt   (q_cnt[QI_TX0]),
        .rx0_cnt   (q_cnt[QI_RX0]),
        .tx1_cnt   (q_cnt[QI_TX1]),
        .rx1_cnt   (q_cnt[QI_RX1]),
        .tx0_full  (q_full[QI_TX0]),
        .rx0_empty (q_empty[QI_RX0]),
        .tx1_full  (q_full[QI_TX1]),
        .rx1_empty (q_empty[QI_RX1]),
        .occ_ch0   (occ_ch0),
        .occ_ch1   (occ_ch1),
        .status    (status),
        .irq       (irq)
    );

    assert_mb_free_R4: assert property (@(posedge clk) disable iff (rst)
        mb_load_valid |-> mb_empty[mb_load_idx]);

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_req_bit_R1: assert property (@(posedge clk) disable iff (rst)
        mb_load_valid |-> mb_load_rec[96]);

    assert_one_release_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rxf_release));

    assert_release_pending_R5: assert property (@(posedge clk) disable iff (rst)
        rxf_release[1] |-> (rxf_count1 != 2'd0 && rxf_count0 == 2'd0));

    assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!mb_load_valid && rxf_release == 2'b00));

    assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (occ_ch0 != 32'd0 || occ_ch1 != 32'd0));

endmodule

// File: tb/canq_dispatch_bench.sv
module canq_dispatch_bench;
    import canq_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst;
    logic [31:0]  ctrl_word;
    logic         host_tx_push, host_tx_chan, host_rx_pop, host_rx_chan;
    logic [127:0] host_tx_rec;
    logic         host_rx_valid;
    logic [127:0] host_rx_rec;
    logic [2:0]   mb_empty;
    logic         mb_load_valid;
    logic [1:0]   mb_load_idx;
    logic [127:0] mb_load_rec;
    logic [1:0]   rxf_count0, rxf_count1, rxf_release;
    logic [127:0] rxf_msg0, rxf_msg1;
    logic [31:0]  occ_ch0, occ_ch1;
    logic [3:0]   status;
    logic         irq;

    canq_dispatch u_canq_dispatch (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .host_tx_push(host_tx_push), .host_tx_chan(host_tx_chan), .host_tx_rec(host_tx_rec),
        .host_rx_pop(host_rx_pop), .host_rx_chan(host_rx_chan),
        .host_rx_valid(host_rx_valid), .host_rx_rec(host_rx_rec),
        .mb_empty(mb_empty), .mb_load_valid(mb_load_valid),
        .mb_load_idx(mb_load_idx), .mb_load_rec(mb_load_rec),
        .rxf_count0(rxf_count0), .rxf_msg0(rxf_msg0),
        .rxf_count1(rxf_count1), .rxf_msg1(rxf_msg1), .rxf_release(rxf_release),
        .occ_ch0(occ_ch0), .occ_ch1(occ_ch1), .status(status), .irq(irq)
    );

    typedef struct {
        int           idx;
        logic [127:0] rec;
    } mb_exp_t;

    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 0;
    mb_exp_t      exp_mb[$];
    logic [127:0] exp_pop[$];
    logic [127:0] f0q[$], f1q[$], m_rx0[$], m_tx0[$];
    int           pend_mb = -1;
    bit           pend_f0 = 0;
    bit           pend_f1 = 0;

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(int s);
        return {32'hA000_0000 | (32'(s) << 4), 16'(s * 3), 16'd8, {8{8'(s)}}};
    endfunction

    function automatic logic [127:0] with_req(logic [127:0] r);
        return r | (128'd1 << 96);
    endfunction

    function automatic void refresh();
        rxf_count0 = (f0q.size() > 3) ? 2'd3 : 2'(f0q.size());
        rxf_count1 = (f1q.size() > 3) ? 2'd3 : 2'(f1q.size());
        rxf_msg0   = (f0q.size() != 0) ? f0q[0] : '0;
        rxf_msg1   = (f1q.size() != 0) ? f1q[0] : '0;
    endfunction

    // one clock: monitor edge outputs, let the edge pass, model the controller, monitor responses
    task automatic tick();
        mb_exp_t e;
        #1;
        if (mb_load_valid === 1'b1) begin
            if (exp_mb.size() == 0) begin
                chk("R4", "unexpected mailbox load", 128'(mb_load_idx), 128'hFFFF);
            end else begin
                e = exp_mb.pop_front();
                chk("R4", "mailbox index", 128'(mb_load_idx), 128'(e.idx));
                chk("R1", "mailbox record", mb_load_rec, e.rec);
            end
            pend_mb = int'(mb_load_idx);
        end
        if (rxf_release[0] === 1'b1) begin pend_f0 = 1; m_rx0.push_back(f0q[0]); end
        if (rxf_release[1] === 1'b1) begin pend_f1 = 1; m_rx0.push_back(f1q[0]); end
        @(posedge clk);
        @(negedge clk);
        if (pend_mb >= 0) mb_empty[pend_mb] = 1'b0;
        pend_mb = -1;
        if (pend_f0) void'(f0q.pop_front());
        if (pend_f1) void'(f1q.pop_front());
        pend_f0 = 0;
        pend_f1 = 0;
        refresh();
        #1;
        if (host_rx_valid === 1'b1) begin
            if (exp_pop.size() == 0) chk("R3", "unexpected pop response", host_rx_rec, 128'hFFFF);
            else chk("R3", "pop record", host_rx_rec, exp_pop.pop_front());
        end
    endtask

    task automatic push_tx(bit ch, logic [127:0] r);
        host_tx_push = 1'b1;
        host_tx_chan = ch;
        host_tx_rec  = r;
        tick();
        host_tx_push = 1'b0;
    endtask

    task automatic pop_rx(bit ch);
        if (!ch && m_rx0.size() != 0) exp_pop.push_back(m_rx0.pop_front());
        else exp_pop.push_back('0);
        host_rx_pop  = 1'b1;
        host_rx_chan = ch;
        tick();
        host_rx_pop  = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctrl_word = '0;
        host_tx_push = 0; host_tx_chan = 0; host_tx_rec = '0;
        host_rx_pop = 0; host_rx_chan = 0; mb_empty = 3'b000;
        refresh();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // reset state
        chk("R6", "reset occ_ch0", 128'(occ_ch0), 0);
        chk("R6", "reset occ_ch1", 128'(occ_ch1), 0);
        chk("R7", "reset status", 128'(status), 0);
        chk("R8", "reset irq", 128'(irq), 0);
        chk("R4", "reset no load", 128'(mb_load_valid), 0);

        ctrl_word = 32'd1;
        tick();

        // R2: queue three records while all mailboxes are busy
        for (int i = 0; i < 3; i++) begin
            m_tx0.push_back(mk(i + 1));
            push_tx(0, mk(i + 1));
        end
        chk("R6", "tx count three", 128'(occ_ch0), {16'd3, 16'd0});
        chk("R7", "status not full", 128'(status), 0);

        // R4: mailboxes 0 and 2 free -> loads in index order, one per cycle
        mb_empty = 3'b101;
        exp_mb.push_back('{0, with_req(m_tx0.pop_front())});
        exp_mb.push_back('{2, with_req(m_tx0.pop_front())});
        repeat (3) tick();
        chk("R4", "loads outstanding", 128'(exp_mb.size()), 0);
        chk("R6", "tx count one", 128'(occ_ch0), {16'd1, 16'd0});
        mb_empty = 3'b010;
        exp_mb.push_back('{1, with_req(m_tx0.pop_front())});
        repeat (2) tick();
        chk("R4", "loads outstanding 2", 128'(exp_mb.size()), 0);
        chk("R6", "tx count zero", 128'(occ_ch0), 0);

        // R5: drain FIFO 0 before FIFO 1
        f0q.push_back(mk(20)); f0q.push_back(mk(21)); f1q.push_back(mk(22));
        refresh();
        repeat (4) tick();
        chk("R5", "fifos drained", 128'(f0q.size() + f1q.size()), 0);
        chk("R6", "rx count three", 128'(occ_ch0), 3);
        chk("R7", "rx nonempty bit", 128'(status), 4'b0010);
        chk("R8", "irq high", 128'(irq), 1);

        // R3: pops in order, then empty pops return zero
        repeat (3) pop_rx(0);
        pop_rx(0);
        pop_rx(1);
        chk("R3", "empty pop keeps counts", 128'(occ_ch0), 0);
        chk("R8", "irq low", 128'(irq), 0);

        // R10: pop and drain on rx0 in one cycle
        f0q.push_back(mk(30)); refresh();
        repeat (2) tick();
        chk("R5", "rx count one", 128'(occ_ch0), 1);
        f0q.push_back(mk(31)); refresh();
        pop_rx(0);
        chk("R10", "rx push+pop count", 128'(occ_ch0), 1);
        pop_rx(0);
        chk("R3", "rx drained", 128'(occ_ch0), 0);

        // R2 / R7: fill channel-1 tx, overflow dropped
        for (int i = 0; i < 33; i++) push_tx(1, mk(100 + i));
        chk("R2", "tx1 holds depth", 128'(occ_ch1), {16'd32, 16'd0});
        chk("R7", "tx1 full bit", 128'(status), 4'b0100);
        chk("R8", "irq on full", 128'(irq), 1);

        for (int i = 0; i < 32; i++) begin
            m_tx0.push_back(mk(200 + i));
            push_tx(0, mk(200 + i));
        end
        chk("R7", "both tx full", 128'(status), 4'b0101);

        // R10: push into full tx0 while a mailbox takes the head
        mb_empty = 3'b001;
        exp_mb.push_back('{0, with_req(m_tx0.pop_front())});
        m_tx0.push_back(mk(300));
        push_tx(0, mk(300));
        chk("R10", "full push+dispatch", 128'(occ_ch0), {16'd32, 16'd0});
        chk("R4", "load seen", 128'(exp_mb.size()), 0);

        // R9: changes without a new enable do not flush
        ctrl_word = 32'd0;
        tick();
        chk("R9", "disable keeps tx0", 128'(occ_ch0), {16'd32, 16'd0});
        tick();
        chk("R9", "steady keeps tx1", 128'(occ_ch1), {16'd32, 16'd0});

        // R11: flush collides with push, free mailboxes and a pending FIFO entry
        ctrl_word = 32'd1;
        mb_empty = 3'b111;
        f1q.push_back(mk(400)); refresh();
        host_tx_push = 1'b1; host_tx_chan = 1'b1; host_tx_rec = mk(401);
        #1;
        chk("R11", "no load in flush", 128'(mb_load_valid), 0);
        chk("R11", "no release in flush", 128'(rxf_release), 0);
        tick();
        host_tx_push = 1'b0;
        m_tx0.delete();
        chk("R9", "flush occ_ch0", 128'(occ_ch0), 0);
        chk("R11", "flush drops push", 128'(occ_ch1), 0);
        chk("R7", "flush status", 128'(status), 0);
        chk("R8", "flush irq", 128'(irq), 0);
        repeat (2) tick();
        chk("R5", "drain resumes", 128'(occ_ch0), 1);
        pop_rx(0);
        chk("R3", "responses consumed", 128'(exp_pop.size()), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule